// File: doc/BRIEF.md
# Programmable High-Speed Pulse Counter Channel

This block is one channel of an industrial pulse counter. A raw count signal is brought into the clock domain by a two-flop synchroniser. Each rising edge of that signal then steps a signed 16-bit accumulator up or down by one. The accumulator is bounded by a programmable lower and upper limit. At a limit it either wraps to the opposite limit (continuous mode) or stays put (single-shot mode).

A single preset output is driven from two compare values. Reaching the ON value sets the output and reaching the OFF value clears it. The host can also force the output state directly. A system-stop input, with a three-way policy, decides what the output pin does while the host is absent. When the counter output is disabled, the pin instead carries a plain host-driven level. A rate meter counts detected edges over a window that is a programmable number of 10 ms steps, and latches the total at the end of each window.

The host configures and steers the channel through a single-cycle command strobe with an opcode and a 16-bit operand. Commands are fire-and-forget control: there is no back-pressure, and every strobe is acted on in the cycle it is sampled. A separate preload strobe copies the stored preload value into the accumulator.

Top module: `hsc_channel`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `rate_o` is 0, the preset state is low, the direction is up, the mode is continuous, the limits are -32768 and 32767, the ON value is 32767, the OFF value is 0 and the timebase is 100 steps (1000 ms).
- R2: Each rising edge of `cnt_in` is seen after the two-flop synchroniser and changes `count_o` by exactly one in the current direction. `cnt_in` must be high for at least two cycles and low for at least two cycles.
- R3: In continuous mode, an up step taken from a value >= the upper limit loads the lower limit, and a down step taken from a value <= the lower limit loads the upper limit.
- R4: In single-shot mode (op 8, data[0]=1), a step that would cross a limit leaves `count_o` unchanged. With data[0]=0 the mode returns to continuous.
- R5: Commands that act on the accumulator are op 1 (clear to 0), op 2 (load the data) and op 3 (add the data modulo 2^16). They take effect on the next clock, and a count edge in the same cycle is dropped.
- R6: Op 6 stores a preload value. A high `preload_stb` copies it into the accumulator. An accumulator command in the same cycle wins over the strobe, and the strobe wins over a count edge.
- R7: Op 4 sets the lower limit, op 5 sets the upper limit, and op 7 sets the direction (data[0]=1 means down, 0 means up).
- R8: When the accumulator takes a new value, the preset state goes high on the following clock if the value equals the ON value (op 10). Otherwise it goes low if the value equals the OFF value (op 11). The ON test is made first.
- R9: Op 12 forces the preset state high and op 13 forces it low on the next clock. A force wins over a preset match in that cycle.
- R10: While `sys_stop` is high, `stop_policy` 0 lets the pin track the preset state, 1 drives the pin low, and 2 freezes the preset state, so that even force commands are ignored. The pin returns to the state when `sys_stop` falls.
- R11: With `out_en` low, `preset_o` equals `host_out`. With `out_en` high, it carries the preset state under the stop policy.
- R12: A rate window lasts timebase x 10 pulses of `ms_tick`. At its end, the number of detected edges in that window is copied to `rate_o` (saturating at 65535). Op 9 sets the timebase, clamping 0 to 1 and values above 6553 to 6553, and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_in | input | 1 | Raw count pulse, asynchronous |
| preload_stb | input | 1 | Copy the preload value into the accumulator |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode (see requirements) |
| cmd_data | input | 16 | Command operand |
| sys_stop | input | 1 | System is in stop state |
| stop_policy | input | 2 | 0 track, 1 force low, 2 hold last |
| out_en | input | 1 | 1: pin carries preset state; 0: pin carries host_out |
| host_out | input | 1 | Host level used when out_en is low |
| preset_o | output | 1 | Output pin |
| count_o | output | 16 | Accumulator, two's complement |
| rate_o | output | 16 | Edges counted in the last complete window |

## Verification
The assertions take it for granted that `cnt_in` is held at each level for at least two cycles, so that every synchronised edge is a clean single-cycle event. They also assume that `stop_policy` never takes the value 3 and that `cmd_op` only carries the listed opcodes. The stimulus drives count pulses as two cycles high and two low, issues each command as a single-cycle strobe with a defined opcode, and uses only policies 0, 1 and 2. One command is timed to land in the same cycle as a count edge, which exercises the priority rule.

// File: rtl/hsc_pkg.sv
`timescale 1ns/1ps
package hsc_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_CLR       = 4'd1,
    OP_LOAD      = 4'd2,
    OP_ADD       = 4'd3,
    OP_SET_LO    = 4'd4,
    OP_SET_HI    = 4'd5,
    OP_SET_PRE   = 4'd6,
    OP_SET_DIR   = 4'd7,
    OP_SET_MODE  = 4'd8,
    OP_SET_TB    = 4'd9,
    OP_SET_ON    = 4'd10,
    OP_SET_OFF   = 4'd11,
    OP_FORCE_ON  = 4'd12,
    OP_FORCE_OFF = 4'd13
  } hsc_op_e;

  typedef enum logic [1:0] {
    STOP_TRACK = 2'd0,
    STOP_LOW   = 2'd1,
    STOP_HOLD  = 2'd2
  } stop_policy_e;
endpackage

// File: rtl/hsc_edge_sync.sv
`timescale 1ns/1ps
module hsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= raw_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/hsc_accum.sv
`timescale 1ns/1ps
module hsc_accum import hsc_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_edge,
  input  logic         preload_stb,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] acc_o,
  output logic         upd_o,
  output logic         down_o,
  output logic         single_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]        ONE   = {{(W-1){1'b0}}, 1'b1};

  logic signed [W-1:0] acc_q, lo_q, hi_q, pre_q, step_v;
  logic                down_q, single_q, upd_q, acc_cmd;

  assign acc_cmd = cmd_valid && (cmd_op == OP_CLR || cmd_op == OP_LOAD || cmd_op == OP_ADD);

  always_comb begin
    if (!down_q)
      step_v = (acc_q >= hi_q) ? (single_q ? acc_q : lo_q) : acc_q + ONE;
    else
      step_v = (acc_q <= lo_q) ? (single_q ? acc_q : hi_q) : acc_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      upd_q    <= 1'b0;
      lo_q     <= S_MIN;
      hi_q     <= S_MAX;
      pre_q    <= '0;
      down_q   <= 1'b0;
      single_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (acc_cmd) begin
        upd_q <= 1'b1;
        case (cmd_op)
          OP_CLR:  acc_q <= '0;
          OP_LOAD: acc_q <= cmd_data;
          default: acc_q <= acc_q + cmd_data;
        endcase
      end else if (preload_stb) begin
        acc_q <= pre_q;
        upd_q <= 1'b1;
      end else if (step_edge) begin
        acc_q <= step_v;
        upd_q <= (step_v != acc_q);
      end
      if (cmd_valid) begin
        case (cmd_op)
          OP_SET_LO:   lo_q     <= cmd_data;
          OP_SET_HI:   hi_q     <= cmd_data;
          OP_SET_PRE:  pre_q    <= cmd_data;
          OP_SET_DIR:  down_q   <= cmd_data[0];
          OP_SET_MODE: single_q <= cmd_data[0];
          default: ;
        endcase
      end
    end
  end

  assign acc_o    = acc_q;
  assign upd_o    = upd_q;
  assign down_o   = down_q;
  assign single_o = single_q;
  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
endmodule

// File: rtl/hsc_preset_out.sv
`timescale 1ns/1ps
module hsc_preset_out import hsc_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] acc,
  input  logic         acc_upd,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic         sys_stop,
  input  logic [1:0]   stop_policy,
  input  logic         out_en,
  input  logic         host_out,
  output logic         pin_o,
  output logic         state_o,
  output logic [W-1:0] on_o
);
  localparam logic [W-1:0] ON_DEF = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] on_q, off_q;
  logic         state_q, holding, low_forced;

  assign holding    = sys_stop && (stop_policy == STOP_HOLD);
  assign low_forced = sys_stop && (stop_policy == STOP_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= ON_DEF;
      off_q   <= '0;
      state_q <= 1'b0;
    end else begin
      if (!holding) begin
        if (cmd_valid && cmd_op == OP_FORCE_ON)       state_q <= 1'b1;
        else if (cmd_valid && cmd_op == OP_FORCE_OFF) state_q <= 1'b0;
        else if (acc_upd) begin
          if (acc == on_q)       state_q <= 1'b1;
          else if (acc == off_q) state_q <= 1'b0;
        end
      end
      if (cmd_valid && cmd_op == OP_SET_ON)  on_q  <= cmd_data;
      if (cmd_valid && cmd_op == OP_SET_OFF) off_q <= cmd_data;
    end
  end

  assign pin_o   = !out_en ? host_out : (low_forced ? 1'b0 : state_q);
  assign state_o = state_q;
  assign on_o    = on_q;
endmodule

// File: rtl/hsc_rate_meter.sv
`timescale 1ns/1ps
module hsc_rate_meter import hsc_pkg::*; #(
  parameter int W           = 16,
  parameter int TBW         = 13,
  parameter int TB_DEF      = 100,
  parameter int TB_MAX      = 6553,
  parameter int MS_PER_STEP = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_edge,
  input  logic         ms_tick,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] rate_o
);
  localparam int MS_W = $clog2(MS_PER_STEP);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_STEP - 1);

  logic [MS_W-1:0] ms_q;
  logic [TBW-1:0]  step_q, tb_q, tb_new;
  logic [W-1:0]    win_q, win_inc, rate_q;
  logic            step_end, win_end, tb_cmd;

  assign tb_cmd   = cmd_valid && cmd_op == OP_SET_TB;
  assign step_end = ms_tick && (ms_q == MS_LAST);
  assign win_end  = step_end && (step_q == tb_q - TBW'(1));
  assign win_inc  = (step_edge && win_q != '1) ? win_q + 1'b1 : win_q;

  always_comb begin
    if (cmd_data == '0)              tb_new = TBW'(1);
    else if (cmd_data > W'(TB_MAX))  tb_new = TBW'(TB_MAX);
    else                             tb_new = cmd_data[TBW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q   <= '0;
      step_q <= '0;
      tb_q   <= TBW'(TB_DEF);
      win_q  <= '0;
      rate_q <= '0;
    end else if (tb_cmd) begin
      tb_q   <= tb_new;
      ms_q   <= '0;
      step_q <= '0;
      win_q  <= '0;
    end else if (win_end) begin
      rate_q <= win_inc;
      win_q  <= '0;
      ms_q   <= '0;
      step_q <= '0;
    end else begin
      win_q <= win_inc;
      if (step_end) begin
        ms_q   <= '0;
        step_q <= step_q + TBW'(1);
      end else if (ms_tick) begin
        ms_q <= ms_q + MS_W'(1);
      end
    end
  end

  assign rate_o = rate_q;
endmodule

// File: rtl/hsc_channel.sv
`timescale 1ns/1ps
module hsc_channel import hsc_pkg::*; #(
  parameter int W           = 16,
  parameter int TBW         = 13,
  parameter int TB_DEF      = 100,
  parameter int TB_MAX      = 6553,
  parameter int MS_PER_STEP = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_in,
  input  logic         preload_stb,
  input  logic         ms_tick,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic         sys_stop,
  input  logic [1:0]   stop_policy,
  input  logic         out_en,
  input  logic         host_out,
  output logic         preset_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] rate_o
);
  logic         cnt_edge, acc_upd, dir_down, single_shot, out_state;
  logic [W-1:0] lim_lo, lim_hi, on_preset;

  hsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_in(cnt_in), .edge_o(cnt_edge)
  );

  hsc_accum #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .step_edge(cnt_edge), .preload_stb(preload_stb),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .acc_o(count_o), .upd_o(acc_upd), .down_o(dir_down), .single_o(single_shot),
    .lo_o(lim_lo), .hi_o(lim_hi)
  );

  hsc_preset_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .acc(count_o), .acc_upd(acc_upd),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .sys_stop(sys_stop), .stop_policy(stop_policy), .out_en(out_en),
    .host_out(host_out), .pin_o(preset_o), .state_o(out_state), .on_o(on_preset)
  );

  hsc_rate_meter #(
    .W(W), .TBW(TBW), .TB_DEF(TB_DEF), .TB_MAX(TB_MAX), .MS_PER_STEP(MS_PER_STEP)
  ) u_rate (
    .clk(clk), .rst(rst), .step_edge(cnt_edge), .ms_tick(ms_tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .rate_o(rate_o)
  );
endmodule

// File: rtl/hsc_channel_chk.sv
`timescale 1ns/1ps
module hsc_channel_chk import hsc_pkg::*; #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [3:0]   cmd_op,
  input logic         preload_stb,
  input logic         sys_stop,
  input logic [1:0]   stop_policy,
  input logic         cnt_edge,
  input logic         acc_upd,
  input logic         dir_down,
  input logic         single_shot,
  input logic [W-1:0] count_o,
  input logic [W-1:0] lim_lo,
  input logic [W-1:0] lim_hi,
  input logic [W-1:0] on_preset,
  input logic         out_state
);
  logic quiet, holding;
  assign quiet   = !cmd_valid && !preload_stb;
  assign holding = sys_stop && stop_policy == STOP_HOLD;

  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (cnt_edge && quiet && !dir_down && ($signed(count_o) < $signed(lim_hi)))
    |=> ($signed(count_o) == $signed($past(count_o)) + 1));

  a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_edge && quiet && !dir_down && !single_shot && ($signed(count_o) >= $signed(lim_hi)))
    |=> (count_o == $past(lim_lo)));

  a_r4_single_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt_edge && quiet && dir_down && single_shot && ($signed(count_o) <= $signed(lim_lo)))
    |=> $stable(count_o));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_CLR) |=> (count_o == '0));

  a_r8_on_hit: assert property (@(posedge clk) disable iff (rst)
    (acc_upd && count_o == on_preset && !cmd_valid && !holding) |=> out_state);

  a_r9_force_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_FORCE_ON && !holding) |=> out_state);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    holding |=> (out_state == $past(out_state)));
endmodule

bind hsc_channel hsc_channel_chk #(.W(W)) chk_i (.*);

// File: tb/hsc_channel_tb.sv
`timescale 1ns/1ps
module hsc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_in = 1'b0, preload_stb = 1'b0, ms_tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        sys_stop = 1'b0;
  logic [1:0]  stop_policy = 2'd0;
  logic        out_en = 1'b1, host_out = 1'b0;
  logic        preset_o;
  logic [15:0] count_o, rate_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hsc_channel dut_i (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .preload_stb(preload_stb), .ms_tick(ms_tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .sys_stop(sys_stop),
    .stop_policy(stop_policy), .out_en(out_en), .host_out(host_out),
    .preset_o(preset_o), .count_o(count_o), .rate_o(rate_o)
  );

  function automatic int s16(int v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_p0, m_p1, m_p2, m_edge, m_down, m_single, m_state, m_upd, m_nupd, m_hold;
  int m_acc, m_nacc, m_lo, m_hi, m_pre, m_on, m_off;
  int m_tb, m_ms, m_step, m_win, m_winc, m_rate, m_op;

  always @(posedge clk) begin
    if (rst) begin
      m_p0 = 0; m_p1 = 0; m_p2 = 0; m_down = 0; m_single = 0; m_state = 0; m_upd = 0;
      m_acc = 0; m_lo = -32768; m_hi = 32767; m_pre = 0; m_on = 32767; m_off = 0;
      m_tb = 100; m_ms = 0; m_step = 0; m_win = 0; m_rate = 0;
    end else begin
      m_op   = cmd_valid ? int'(cmd_op) : 0;
      m_edge = m_p1 && !m_p2;
      m_hold = sys_stop && stop_policy == 2'd2;
      if (!m_hold) begin
        if (m_op == 12) m_state = 1;
        else if (m_op == 13) m_state = 0;
        else if (m_upd) begin
          if (m_acc == m_on) m_state = 1;
          else if (m_acc == m_off) m_state = 0;
        end
      end
      if (m_op == 10) m_on = s16(int'(cmd_data));
      if (m_op == 11) m_off = s16(int'(cmd_data));
      m_nacc = m_acc; m_nupd = 0;
      if (m_op == 1 || m_op == 2 || m_op == 3) begin
        m_nupd = 1;
        if (m_op == 1) m_nacc = 0;
        else if (m_op == 2) m_nacc = s16(int'(cmd_data));
        else m_nacc = s16(m_acc + int'(cmd_data));
      end else if (preload_stb) begin
        m_nacc = m_pre; m_nupd = 1;
      end else if (m_edge) begin
        if (!m_down) m_nacc = (m_acc >= m_hi) ? (m_single ? m_acc : m_lo) : m_acc + 1;
        else         m_nacc = (m_acc <= m_lo) ? (m_single ? m_acc : m_hi) : m_acc - 1;
        m_nupd = (m_nacc != m_acc);
      end
      m_acc = m_nacc; m_upd = m_nupd;
      if (m_op == 4) m_lo = s16(int'(cmd_data));
      if (m_op == 5) m_hi = s16(int'(cmd_data));
      if (m_op == 6) m_pre = s16(int'(cmd_data));
      if (m_op == 7) m_down = cmd_data[0];
      if (m_op == 8) m_single = cmd_data[0];
      if (m_op == 9) begin
        m_tb = (cmd_data == 0) ? 1 : (int'(cmd_data) > 6553 ? 6553 : int'(cmd_data));
        m_ms = 0; m_step = 0; m_win = 0;
      end else begin
        m_winc = (m_edge && m_win < 65535) ? m_win + 1 : m_win;
        if (ms_tick && m_ms == 9 && m_step == m_tb - 1) begin
          m_rate = m_winc; m_win = 0; m_ms = 0; m_step = 0;
        end else begin
          m_win = m_winc;
          if (ms_tick) begin
            if (m_ms == 9) begin m_ms = 0; m_step++; end
            else m_ms++;
          end
        end
      end
      m_p2 = m_p1; m_p1 = m_p0; m_p0 = cnt_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3 model count", int'($signed(count_o)), m_acc);
      chk("R12 model rate", int'(rate_o), m_rate);
      chk("R8/R10/R11 model pin", int'(preset_o),
          !out_en ? int'(host_out) : ((sys_stop && stop_policy == 2'd1) ? 0 : int'(m_state)));
    end
  end

  // millisecond tick: one pulse every 5 clocks
  int tick_div = 0;
  always @(posedge clk) begin
    #1;
    tick_div = (tick_div == 4) ? 0 : tick_div + 1;
    ms_tick = (tick_div == 0);
  end

  task automatic send(int op, int data);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op[3:0]; cmd_data = data[15:0];
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 cnt_in = 1'b1;
      @(posedge clk);
      @(posedge clk); #1 cnt_in = 1'b0;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset pin", int'(preset_o), 0);
    chk("R1 reset rate", int'(rate_o), 0);

    pulses(5); settle();
    chk("R2 five up edges", int'($signed(count_o)), 5);
    send(7, 1); pulses(2); settle();
    chk("R7 down direction", int'($signed(count_o)), 3);
    send(7, 0); send(2, 32766); settle();
    chk("R5 load", int'($signed(count_o)), 32766);
    pulses(1); settle();
    chk("R8 on preset reached", int'(preset_o), 1);
    pulses(1); settle();
    chk("R3 wrap to lower limit", int'($signed(count_o)), -32768);
    send(1, 0); settle();
    chk("R5 clear", int'($signed(count_o)), 0);
    chk("R8 off preset reached", int'(preset_o), 0);

    send(4, -5); send(5, 5); send(2, 4); pulses(3); settle();
    chk("R3 R7 up wrap with limits", int'($signed(count_o)), -4);
    send(7, 1); send(2, -4); pulses(2); settle();
    chk("R3 down wrap to upper", int'($signed(count_o)), 5);
    send(8, 1); send(2, -3); pulses(4); settle();
    chk("R4 single-shot low", int'($signed(count_o)), -5);
    send(7, 0); send(2, 3); pulses(4); settle();
    chk("R4 single-shot high", int'($signed(count_o)), 5);

    send(3, 100); settle();
    chk("R5 add positive", int'($signed(count_o)), 105);
    send(3, -200); settle();
    chk("R5 add negative", int'($signed(count_o)), -95);

    // R5 priority: load lands in the cycle the edge is detected
    @(posedge clk); #1 cnt_in = 1'b1;
    @(posedge clk);
    send(2, 77);
    #1 cnt_in = 1'b0;
    settle();
    chk("R5 command beats edge", int'($signed(count_o)), 77);

    send(6, 1234);
    @(posedge clk); #1 preload_stb = 1'b1;
    @(posedge clk); #1 preload_stb = 1'b0;
    settle();
    chk("R6 preload strobe", int'($signed(count_o)), 1234);

    send(8, 0); send(5, 2000); send(10, 1240); pulses(6); settle();
    chk("R8 programmed on value", int'(preset_o), 1);
    send(11, 1242); pulses(2); settle();
    chk("R8 programmed off value", int'(preset_o), 0);

    send(12, 0); settle();
    chk("R9 force on", int'(preset_o), 1);
    send(13, 0); settle();
    chk("R9 force off", int'(preset_o), 0);
    send(12, 0); settle();

    @(posedge clk); #1 sys_stop = 1'b1; stop_policy = 2'd1;
    @(negedge clk);
    chk("R10 stop forces pin low", int'(preset_o), 0);
    @(posedge clk); #1 stop_policy = 2'd2;
    send(13, 0); settle();
    chk("R10 hold ignores force off", int'(preset_o), 1);
    @(posedge clk); #1 sys_stop = 1'b0; stop_policy = 2'd0;
    @(negedge clk);
    chk("R10 pin back after stop", int'(preset_o), 1);

    @(posedge clk); #1 out_en = 1'b0; host_out = 1'b0;
    @(negedge clk);
    chk("R11 disabled pin follows host low", int'(preset_o), 0);
    @(posedge clk); #1 host_out = 1'b1; send(13, 0);
    @(negedge clk);
    chk("R11 disabled pin follows host high", int'(preset_o), 1);
    @(posedge clk); #1 out_en = 1'b1;

    send(9, 0); pulses(40); settle();
    n_chk++;
    if (rate_o < 16'd12 || rate_o > 16'd13) begin
      n_fail++;
      $display("FAIL R12 rate window actual %0d expected 12..13", rate_o);
    end
    send(9, 7000); pulses(3); settle();
    chk("R12 long window not yet ended", int'(rate_o), m_rate);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule